// File: doc/BRIEF.md
# Universal Shift-Storage Register with Shared Bidirectional Port

This block is a register of parameterised width (eight bits by default) that can hold its contents, shift toward the high stage, shift toward the low stage, or take a whole word in parallel. One set of three-state terminals does two jobs. It presents the stored word when reading is allowed, and it accepts the word to be captured during a parallel load. The block releases those terminals by itself whenever a load is selected.

A synchronous active-low clear overrides every mode. Two active-low enables can float the shared terminals. They have no effect on the register itself, which keeps shifting, loading or clearing while its pins are released. The lowest and highest stages each have a dedicated output that is never released. Several instances can therefore be chained into a longer word by feeding one end output into the next instance's serial input.

The internal drive-enable and the stored word are also brought out. A bus partner can use them to avoid contention, and a bench can use them to observe the state while the pins float.

Top module: `usr_top`

## Requirements
- R1: With select `modeSel` = 2'b00 (bit 1 and bit 0 both low) and clear high, the stored word is unchanged by a rising clock edge.
- R2: With `modeSel` = 2'b01 and clear high, a rising edge moves every stage i to stage i+1, and `serToHigh` enters stage 0.
- R3: With `modeSel` = 2'b10 and clear high, a rising edge moves every stage i+1 to stage i, and `serToLow` enters the top stage.
- R4: With `modeSel` = 2'b11 and clear high, a rising edge stores the value present on `ioBus`.
- R5: When `clearN` is low at a rising edge, the stored word becomes all zeros, whatever the mode, including a load.
- R6: While `modeSel` = 2'b11, the block does not drive `ioBus`, whatever the enables are.
- R7: The block drives the stored word onto `ioBus` exactly when both bits of `outEnN` are low and the mode is not a load. Otherwise `ioBus` is released to high impedance.
- R8: The value of `outEnN` has no effect on holding, shifting, loading or clearing.
- R9: `endLow` always equals stage 0 and `endHigh` always equals the top stage. Neither output is ever released. Feeding `endHigh` into a second instance's `serToHigh` gives a shift across twice the width.
- R10: `busDriveEn` shows whether the block is driving `ioBus`, and `busDataOut` always shows the stored word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clearN | input | 1 | Synchronous clear, active low |
| modeSel | input | 2 | 00 hold, 01 shift up, 10 shift down, 11 parallel load |
| outEnN | input | 2 | Two active-low terminal enables; both must be low to drive |
| serToHigh | input | 1 | Serial bit entering stage 0 when shifting up |
| serToLow | input | 1 | Serial bit entering the top stage when shifting down |
| ioBus | inout | WIDTH | Shared terminals: stored word out, load word in |
| endLow | output | 1 | Stage 0, always driven |
| endHigh | output | 1 | Top stage, always driven |
| busDriveEn | output | 1 | High while the block drives ioBus |
| busDataOut | output | WIDTH | Stored word |

## Verification
The hardest situation to reach from the ports is a register that keeps changing while its terminals float. The pins then show nothing, so a wrong update would go unseen. The stimulus shifts and loads with one or both enables high, reads the state through `busDataOut` and the end outputs, and then enables the pins again to confirm the word. A clear is also applied in the same cycle as a load, and two instances are chained so that a single set bit has to cross the boundary between them.

// File: rtl/usr_pkg.sv
package usr_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DOWN = 2'b10,
    MODE_LOAD = 2'b11
  } usr_mode_e;

  typedef struct packed {
    logic clr;
    logic up;
    logic down;
    logic load;
    logic drive;
  } usr_strobe_t;
endpackage

// File: rtl/usr_ctrl.sv
module usr_ctrl
  import usr_pkg::*;
(
  input  logic        clearN,
  input  logic [1:0]  modeSel,
  input  logic [1:0]  outEnN,
  output usr_strobe_t strobe
);
  usr_mode_e mode;

  always_comb begin
    mode = usr_mode_e'(modeSel);
    strobe = '0;
    strobe.clr = ~clearN;
    unique case (mode)
      MODE_UP:   strobe.up   = clearN;
      MODE_DOWN: strobe.down = clearN;
      MODE_LOAD: strobe.load = clearN;
      default:   ;
    endcase
    // pins float while loading, or if either enable is high
    strobe.drive = (mode != MODE_LOAD) && (outEnN == 2'b00);
  end
endmodule

// File: rtl/usr_datapath.sv
module usr_datapath
  import usr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  usr_strobe_t      strobe,
  input  logic             serToHigh,
  input  logic             serToLow,
  input  logic [WIDTH-1:0] loadWord,
  output logic [WIDTH-1:0] stageQ
);
  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] nextQ;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic fromBelow;
    logic fromAbove;
    if (i == 0) begin : g_low
      assign fromBelow = serToHigh;
    end else begin : g_mid_low
      assign fromBelow = stageQ[i-1];
    end
    if (i == TOP) begin : g_high
      assign fromAbove = serToLow;
    end else begin : g_mid_high
      assign fromAbove = stageQ[i+1];
    end

    always_comb begin
      if (strobe.clr)       nextQ[i] = 1'b0;
      else if (strobe.load) nextQ[i] = loadWord[i];
      else if (strobe.up)   nextQ[i] = fromBelow;
      else if (strobe.down) nextQ[i] = fromAbove;
      else                  nextQ[i] = stageQ[i];
    end
  end

  always_ff @(posedge clk) begin
    stageQ <= nextQ;
  end
endmodule

// File: rtl/usr_top.sv
module usr_top
  import usr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clearN,
  input  logic [1:0]       modeSel,
  input  logic [1:0]       outEnN,
  input  logic             serToHigh,
  input  logic             serToLow,
  inout  wire  [WIDTH-1:0] ioBus,
  output logic             endLow,
  output logic             endHigh,
  output logic             busDriveEn,
  output logic [WIDTH-1:0] busDataOut
);
  usr_strobe_t      strobe;
  logic [WIDTH-1:0] stageQ;

  usr_ctrl i_ctrl (
    .clearN (clearN),
    .modeSel(modeSel),
    .outEnN (outEnN),
    .strobe (strobe)
  );

  usr_datapath #(.WIDTH(WIDTH)) i_datapath (
    .clk      (clk),
    .strobe   (strobe),
    .serToHigh(serToHigh),
    .serToLow (serToLow),
    .loadWord (ioBus),
    .stageQ   (stageQ)
  );

  assign ioBus      = strobe.drive ? stageQ : {WIDTH{1'bz}};
  assign busDriveEn = strobe.drive;
  assign busDataOut = stageQ;
  assign endLow     = stageQ[0];
  assign endHigh    = stageQ[WIDTH-1];
endmodule

// File: rtl/usr_checker.sv
module usr_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             clearN,
  input logic [1:0]       modeSel,
  input logic [1:0]       outEnN,
  input logic             serToHigh,
  input logic             serToLow,
  input logic [WIDTH-1:0] ioBus,
  input logic             endLow,
  input logic             endHigh,
  input logic             busDriveEn,
  input logic [WIDTH-1:0] busDataOut
);
  logic known = 1'b0;
  always_ff @(posedge clk) begin
    if (!clearN || modeSel == 2'b11) known <= 1'b1;
  end

  assert_hold_R1: assert property (@(posedge clk) disable iff (!known)
    (clearN && modeSel == 2'b00) |=> $stable(busDataOut));
  assert_up_R2: assert property (@(posedge clk) disable iff (!known)
    (clearN && modeSel == 2'b01) |=>
      busDataOut == {$past(busDataOut[WIDTH-2:0]), $past(serToHigh)});
  assert_down_R3: assert property (@(posedge clk) disable iff (!known)
    (clearN && modeSel == 2'b10) |=>
      busDataOut == {$past(serToLow), $past(busDataOut[WIDTH-1:1])});
  assert_load_R4: assert property (@(posedge clk) disable iff (!known)
    (clearN && modeSel == 2'b11) |=> busDataOut == $past(ioBus));
  assert_clear_R5: assert property (@(posedge clk) disable iff (!known)
    !clearN |=> busDataOut == '0);
  assert_release_R6: assert property (@(posedge clk) disable iff (!known)
    (modeSel == 2'b11) |-> !busDriveEn);
  assert_gate_R7: assert property (@(posedge clk) disable iff (!known)
    (outEnN != 2'b00) |-> !busDriveEn);
  assert_ends_R9: assert property (@(posedge clk) disable iff (!known)
    (endLow == busDataOut[0]) && (endHigh == busDataOut[WIDTH-1]));
endmodule

bind usr_top usr_checker #(.WIDTH(WIDTH)) i_usr_checker (
  .clk       (clk),
  .clearN    (clearN),
  .modeSel   (modeSel),
  .outEnN    (outEnN),
  .serToHigh (serToHigh),
  .serToLow  (serToLow),
  .ioBus     (ioBus),
  .endLow    (endLow),
  .endHigh   (endHigh),
  .busDriveEn(busDriveEn),
  .busDataOut(busDataOut)
);

// File: tb/test_usr_top.sv
module test_usr_top;
  localparam int W = 8;
  localparam int NVEC = 12;

  typedef struct packed {
    logic       clrN;
    logic [1:0] mode;
    logic [1:0] oeN;
    logic       sr;
    logic       sl;
    logic [7:0] din;
    logic [7:0] expQ;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 8'h00, 8'h00},  // R5 clear
    '{1'b1, 2'b11, 2'b00, 1'b0, 1'b0, 8'hA5, 8'hA5},  // R4 load
    '{1'b1, 2'b00, 2'b00, 1'b1, 1'b1, 8'h00, 8'hA5},  // R1 hold
    '{1'b1, 2'b01, 2'b00, 1'b1, 1'b0, 8'h00, 8'h4B},  // R2 up, 1 in
    '{1'b1, 2'b01, 2'b11, 1'b0, 1'b1, 8'h00, 8'h96},  // R2/R8 up, pins off
    '{1'b1, 2'b10, 2'b00, 1'b0, 1'b1, 8'h00, 8'hCB},  // R3 down, 1 in
    '{1'b1, 2'b10, 2'b01, 1'b1, 1'b0, 8'h00, 8'h65},  // R3/R8 down
    '{1'b1, 2'b11, 2'b11, 1'b0, 1'b0, 8'h3C, 8'h3C},  // R4/R8 load, pins off
    '{1'b0, 2'b11, 2'b00, 1'b0, 1'b0, 8'hFF, 8'h00},  // R5 clear beats load
    '{1'b1, 2'b11, 2'b01, 1'b0, 1'b0, 8'h81, 8'h81},  // R4 load
    '{1'b1, 2'b01, 2'b10, 1'b0, 1'b0, 8'h00, 8'h02},  // R2/R8
    '{1'b1, 2'b10, 2'b00, 1'b0, 1'b0, 8'h00, 8'h01}   // R3
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       clearN = 1'b1, clearN2 = 1'b1;
  logic [1:0] modeSel = 2'b00, modeSel2 = 2'b00;
  logic [1:0] outEnN = 2'b11;
  logic       serToHigh = 1'b0, serToLow = 1'b0;
  logic       tbDrv = 1'b0;
  logic [W-1:0] tbData = '0;
  wire  [W-1:0] ioBus, ioBus2;
  logic endLow, endHigh, busDriveEn, endLow2, endHigh2, busDriveEn2;
  logic [W-1:0] busDataOut, busDataOut2;

  assign ioBus  = tbDrv ? tbData : {W{1'bz}};
  assign ioBus2 = {W{1'bz}};

  usr_top #(.WIDTH(W)) i_usr_top (
    .clk(clk), .clearN(clearN), .modeSel(modeSel), .outEnN(outEnN),
    .serToHigh(serToHigh), .serToLow(serToLow), .ioBus(ioBus),
    .endLow(endLow), .endHigh(endHigh), .busDriveEn(busDriveEn),
    .busDataOut(busDataOut));

  usr_top #(.WIDTH(W)) i_second (
    .clk(clk), .clearN(clearN2), .modeSel(modeSel2), .outEnN(2'b11),
    .serToHigh(endHigh), .serToLow(1'b0), .ioBus(ioBus2),
    .endLow(endLow2), .endHigh(endHigh2), .busDriveEn(busDriveEn2),
    .busDataOut(busDataOut2));

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    clearN = v.clrN; modeSel = v.mode; outEnN = v.oeN;
    serToHigh = v.sr; serToLow = v.sl;
    tbDrv = (v.mode == 2'b11); tbData = v.din;
    #1;
    // R6/R7 combinational drive decision
    check("R6_R7 drive", 16'(busDriveEn), 16'(v.mode != 2'b11 && v.oeN == 2'b00));
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    for (int i = 0; i < NVEC; i++) begin
      apply(VECS[i]);
      check("R1-5 state busDataOut R10", 16'(busDataOut), 16'(VECS[i].expQ));
      check("R9 ends", {14'd0, endHigh, endLow}, {14'd0, VECS[i].expQ[7], VECS[i].expQ[0]});
    end
    // R7: with pins enabled and hold, the bus shows the word; disabled floats
    tbDrv = 1'b0; modeSel = 2'b00; clearN = 1'b1; outEnN = 2'b00; #1;
    check("R7 bus driven", 16'(ioBus), 16'h0001);
    outEnN = 2'b10; #1;
    check("R7 bus floats", 16'(ioBus === {W{1'bz}}), 16'd1);
    // R6: load with enables low still releases pins
    modeSel = 2'b11; outEnN = 2'b00; #1;
    check("R6 load releases", 16'(ioBus === {W{1'bz}}), 16'd1);
    modeSel = 2'b00;
    @(negedge clk);
    // R9 cascade: 16-bit shift up across two instances
    tbDrv = 1'b1; tbData = 8'h01; modeSel = 2'b11; clearN2 = 1'b0;
    @(posedge clk); @(negedge clk);
    tbDrv = 1'b0; clearN2 = 1'b1; modeSel = 2'b01; modeSel2 = 2'b01; serToHigh = 1'b0;
    for (int s = 1; s <= 15; s++) begin
      @(posedge clk); @(negedge clk);
      if (s == 8) check("R9 cascade 8", {busDataOut2, busDataOut}, 16'h0100);
    end
    check("R9 cascade 15", {busDataOut2, busDataOut}, 16'h8000);
    check("R9 cascade end", 16'(endHigh2), 16'd1);
    // R5: clear during shift down with pins off
    modeSel = 2'b10; outEnN = 2'b11; serToLow = 1'b1; clearN = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R5 clear over shift", 16'(busDataOut), 16'h0000);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule